// File: doc/BRIEF.md
# Halt-Aware Clock Power Controller

This block produces the clock enables that pace a processor core and its on-chip peripherals from a single input clock. At full speed both enables pulse on one input cycle in every two, so the internal operating rate is half the input clock. A run-time power-save divider can slow that rate by a power-of-two factor. The slower rate applies to the core and to the peripherals alike.

A halt indication from the core can also stop clocks, depending on the programmed halt mode. Idle mode stops only the core enable. Power-down mode stops both enables and drops the oscillator run control. With no halt mode selected, a halt has no effect. An enabled interrupt or wake event returns the block to full running on the next input clock edge. A reset does the same.

The controller is built around a three-state gating machine:

- States: `ST_RUN`, `ST_IDLE`, `ST_PDOWN`.
- Transitions:
  - RUN→IDLE on a halt in idle mode.
  - RUN→PDOWN on a halt in power-down mode.
  - IDLE→RUN and PDOWN→RUN on a wake event.
  - Every other case holds the current state.

Top module: `clk_pwr_ctrl`

## Requirements
- R1: After reset the block is in the running state with the oscillator run control high, power-save off, halt mode none, and a divided period of 2 input cycles.
- R2: In the running state with power-save off, `core_ce_o` and `periph_ce_o` are high together on every second input cycle, the first pulse falling in the second cycle after reset.
- R3: With power-save on, divider select codes 0, 1, 2, 3, 4 and 5 give divisors 1, 4, 8, 16, 32 and 64. The enables then pulse once every 2×divisor input cycles.
- R4: Divider select codes 6 and 7 act as divisor 1. When power-save is off, the select code has no effect and the divisor is 1.
- R5: A new divisor is first applied at the end of the divided period that is running when it was written. The old period always completes at its old length, so no shortened pulse spacing occurs.
- R6: Halt mode code 1 (idle): a halt sampled in the running state enters the idle state. In that state `core_ce_o` stays low, while `periph_ce_o` keeps its divided rate and `osc_run_o` stays high.
- R7: Halt mode code 2 (power-down): a halt sampled in the running state enters the power-down state. In that state both enables and `osc_run_o` are low, and the divider phase is frozen until wake.
- R8: Halt mode code 0 (none): a halt is ignored and all outputs keep their running behaviour.
- R9: A wake event in the idle or power-down state returns to the running state at the next clock edge. A wake event in the running state has no effect.
- R10: `core_ce_o` is never high unless `periph_ce_o` is high in the same cycle. With power-save on, the peripheral enable runs at the reduced rate.
- R11: Halt mode code 3 behaves as mode none. The halt mode, power-save flag and select code are all captured together on a write strobe, and they act from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Write strobe for the mode register |
| cfg_halt_mode_i | input | 2 | Halt mode code: 0 none, 1 idle, 2 power-down, 3 none |
| cfg_psave_en_i | input | 1 | Power-save divider enable |
| cfg_div_sel_i | input | 3 | Divider select code |
| halt_i | input | 1 | Core has executed a halt (one-cycle pulse) |
| wake_i | input | 1 | Enabled interrupt / wake event |
| core_ce_o | output | 1 | Clock enable for execution and bus interface logic |
| periph_ce_o | output | 1 | Clock enable for peripherals |
| osc_run_o | output | 1 | Oscillator run control |

## Verification
The bench runs a reference model that advances in step with the design and compares all three outputs on every cycle. A wrong divider phase or period shows as a misplaced enable pulse within one divided period, which is at most 128 input cycles. A wrong gating state shows in the first cycle after the faulty transition, either on `osc_run_o` or on the next expected enable pulse. A divisor applied too early shows as a shortened pulse spacing right at the write.

// File: rtl/clkpwr_pkg.sv
package clkpwr_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_PDOWN = 2'd2
    } gate_state_e;

    typedef enum logic [1:0] {
        HM_NONE     = 2'd0,
        HM_IDLE     = 2'd1,
        HM_PDOWN    = 2'd2,
        HM_NONE_ALT = 2'd3
    } halt_mode_e;

endpackage

// File: rtl/clkpwr_cfg_regs.sv
module clkpwr_cfg_regs
    import clkpwr_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 6,
    localparam int FACT_W   = MAX_SHIFT + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        mode_i,
    input  logic              psave_i,
    input  logic [SEL_W-1:0]  sel_i,
    output halt_mode_e        mode_o,
    output logic [FACT_W-1:0] factor_o
);

    logic [1:0]       mode_q;
    logic             psave_q;
    logic [SEL_W-1:0] sel_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            mode_q  <= 2'd0;
            psave_q <= 1'b0;
            sel_q   <= '0;
        end else if (wr_i) begin
            mode_q  <= mode_i;
            psave_q <= psave_i;
            sel_q   <= sel_i;
        end
    end

    assign mode_o = halt_mode_e'(mode_q);

    // Codes 1..MAX_SHIFT-1 map to 2^(code+1); everything else is divide-by-1.
    always_comb begin
        factor_o = FACT_W'(1);
        if (psave_q && (int'(sel_q) >= 1) && (int'(sel_q) <= MAX_SHIFT - 1)) begin
            factor_o = FACT_W'(1) << (int'(sel_q) + 1);
        end
    end

endmodule

// File: rtl/clkpwr_divider.sv
module clkpwr_divider #(
    parameter int FACT_W   = 7,
    parameter int BASE_DIV = 2,
    localparam int PER_W   = FACT_W + $clog2(BASE_DIV)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              freeze_i,
    input  logic [FACT_W-1:0] factor_i,
    output logic              tick_o
);

    logic [PER_W-1:0] cnt_q;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] per_req;

    assign per_req = PER_W'(int'(factor_i) * BASE_DIV);
    assign tick_o  = !freeze_i && (cnt_q == per_q - PER_W'(1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            per_q <= PER_W'(BASE_DIV);
        end else if (!freeze_i) begin
            if (tick_o) begin
                cnt_q <= '0;
                per_q <= per_req;
            end else begin
                cnt_q <= cnt_q + PER_W'(1);
            end
        end
    end

    assert_period_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick_o |=> $stable(per_q));

    assert_phase_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q < per_q);

    assert_phase_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_i |=> $stable(cnt_q));

endmodule

// File: rtl/clkpwr_gate_fsm.sv
module clkpwr_gate_fsm
    import clkpwr_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        halt_i,
    input  logic        wake_i,
    input  halt_mode_e  mode_i,
    input  logic        tick_i,
    output logic        freeze_o,
    output logic        core_ce_o,
    output logic        periph_ce_o,
    output logic        osc_run_o
);

    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (halt_i) begin
                    unique case (mode_i)
                        HM_IDLE:  state_d = ST_IDLE;
                        HM_PDOWN: state_d = ST_PDOWN;
                        default:  state_d = ST_RUN;
                    endcase
                end
            end
            ST_IDLE:  if (wake_i) state_d = ST_RUN;
            ST_PDOWN: if (wake_i) state_d = ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        freeze_o    = 1'b0;
        core_ce_o   = 1'b0;
        periph_ce_o = 1'b0;
        osc_run_o   = 1'b1;
        unique case (state_q)
            ST_RUN: begin
                core_ce_o   = tick_i;
                periph_ce_o = tick_i;
            end
            ST_IDLE: begin
                periph_ce_o = tick_i;
            end
            ST_PDOWN: begin
                freeze_o  = 1'b1;
                osc_run_o = 1'b0;
            end
            default: ;
        endcase
    end

    assert_wake_resumes_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_RUN && wake_i) |=> (state_q == ST_RUN && osc_run_o));

    assert_none_ignores_halt_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && (mode_i == HM_NONE || mode_i == HM_NONE_ALT)) |=> state_q == ST_RUN);

    assert_idle_core_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && halt_i && mode_i == HM_IDLE) |=> (!core_ce_o && osc_run_o));

    assert_pdown_all_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && halt_i && mode_i == HM_PDOWN) |=> (!osc_run_o && !periph_ce_o));

endmodule

// File: rtl/clk_pwr_ctrl.sv
module clk_pwr_ctrl
    import clkpwr_pkg::*;
#(
    parameter int SEL_W     = 3,
    parameter int MAX_SHIFT = 6,
    parameter int BASE_DIV  = 2,
    localparam int FACT_W   = MAX_SHIFT + 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cfg_wr_i,
    input  logic [1:0]       cfg_halt_mode_i,
    input  logic             cfg_psave_en_i,
    input  logic [SEL_W-1:0] cfg_div_sel_i,
    input  logic             halt_i,
    input  logic             wake_i,
    output logic             core_ce_o,
    output logic             periph_ce_o,
    output logic             osc_run_o
);

    halt_mode_e        mode;
    logic [FACT_W-1:0] factor;
    logic              tick;
    logic              freeze;

    clkpwr_cfg_regs #(.SEL_W(SEL_W), .MAX_SHIFT(MAX_SHIFT)) u_cfg (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (cfg_wr_i),
        .mode_i   (cfg_halt_mode_i),
        .psave_i  (cfg_psave_en_i),
        .sel_i    (cfg_div_sel_i),
        .mode_o   (mode),
        .factor_o (factor)
    );

    clkpwr_divider #(.FACT_W(FACT_W), .BASE_DIV(BASE_DIV)) u_div (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .freeze_i (freeze),
        .factor_i (factor),
        .tick_o   (tick)
    );

    clkpwr_gate_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .halt_i      (halt_i),
        .wake_i      (wake_i),
        .mode_i      (mode),
        .tick_i      (tick),
        .freeze_o    (freeze),
        .core_ce_o   (core_ce_o),
        .periph_ce_o (periph_ce_o),
        .osc_run_o   (osc_run_o)
    );

    assert_core_needs_periph_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_ce_o |-> periph_ce_o);

    assert_osc_off_silences_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !osc_run_o |-> (!core_ce_o && !periph_ce_o));

endmodule

// File: tb/clk_pwr_ctrl_tb_top.sv
module clk_pwr_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr = 1'b0;
    logic [1:0] hmode = 2'd0;
    logic       ps = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       halt = 1'b0;
    logic       wake = 1'b0;
    logic       core_ce, periph_ce, osc_run;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model state: 0 run, 1 idle, 2 power-down
    int m_st, m_ph, m_len;
    int m_mode, m_ps, m_sel;

    always #10 clk = ~clk;

    clk_pwr_ctrl dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cfg_wr_i        (wr),
        .cfg_halt_mode_i (hmode),
        .cfg_psave_en_i  (ps),
        .cfg_div_sel_i   (sel),
        .halt_i          (halt),
        .wake_i          (wake),
        .core_ce_o       (core_ce),
        .periph_ce_o     (periph_ce),
        .osc_run_o       (osc_run)
    );

    function automatic int divisor(int p, int code);
        if (p == 0) return 1;
        case (code)
            1: return 4;
            2: return 8;
            3: return 16;
            4: return 32;
            5: return 64;
            default: return 1;
        endcase
    endfunction

    // Called at a negedge: compare, then advance the model across the next posedge.
    task automatic step(input string tag);
        bit t, e_core, e_per, e_osc;
        t      = (m_st != 2) && (m_ph == m_len - 1);
        e_core = t && (m_st == 0);
        e_per  = t && (m_st != 2);
        e_osc  = (m_st != 2);
        vectors++;
        if (core_ce !== e_core || periph_ce !== e_per || osc_run !== e_osc) begin
            errors++;
            $display("FAIL %s: core/periph/osc actual %b%b%b expected %b%b%b",
                     tag, core_ce, periph_ce, osc_run, e_core, e_per, e_osc);
        end
        if (m_st != 2) begin
            if (t) begin
                m_ph  = 0;
                m_len = 2 * divisor(m_ps, m_sel);
            end else begin
                m_ph++;
            end
        end
        if (m_st == 0) begin
            if (halt && m_mode == 1) m_st = 1;
            else if (halt && m_mode == 2) m_st = 2;
        end else if (wake) begin
            m_st = 0;
        end
        if (wr) begin
            m_mode = hmode;
            m_ps   = ps;
            m_sel  = sel;
        end
        @(posedge clk);
        @(negedge clk);
        wr   = 1'b0;
        halt = 1'b0;
        wake = 1'b0;
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic write_cfg(input int md, input int p, input int s, input string tag);
        wr = 1'b1; hmode = 2'(md); ps = p[0]; sel = 3'(s);
        step(tag);
    endtask

    initial begin
        m_st = 0; m_ph = 0; m_len = 2; m_mode = 0; m_ps = 0; m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 full-speed cadence
        run(1, "R1");
        run(20, "R2");
        // R3 each valid code, R5 boundary behaviour on every change
        for (int c = 0; c <= 5; c++) begin
            write_cfg(0, 1, c, "R5");
            run(300, "R3");
        end
        // R4 unused codes and power-save off
        write_cfg(0, 1, 6, "R4");
        run(140, "R4");
        write_cfg(0, 1, 7, "R4");
        run(20, "R4");
        write_cfg(0, 0, 5, "R4");
        run(30, "R4");
        // R5 slow to fast mid-period
        write_cfg(0, 1, 5, "R5");
        run(170, "R5");
        write_cfg(0, 1, 0, "R5");
        run(150, "R5");
        // R8 halt ignored in mode none, R11 code 3 also none
        halt = 1'b1; step("R8");
        run(10, "R8");
        write_cfg(3, 0, 0, "R11");
        halt = 1'b1; step("R11");
        run(10, "R11");
        // R9 wake in run has no effect
        wake = 1'b1; step("R9");
        run(6, "R9");
        // R6 idle with R10 peripherals at reduced rate
        write_cfg(1, 1, 1, "R11");
        run(9, "R10");
        halt = 1'b1; step("R6");
        run(40, "R10");
        wake = 1'b1; step("R9");
        run(20, "R9");
        // R7 power-down freezes phase, R9 wake resumes
        write_cfg(2, 1, 2, "R11");
        run(5, "R7");
        halt = 1'b1; step("R7");
        run(50, "R7");
        wake = 1'b1; step("R9");
        run(40, "R9");
        write_cfg(2, 0, 0, "R7");
        run(3, "R7");
        halt = 1'b1; step("R7");
        run(8, "R7");
        wake = 1'b1; step("R9");
        run(10, "R2");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule